// File: doc/BRIEF.md
# Serial Port Rate Reconfiguration Controller

This block owns the signaling-rate code and the power-down state of a group of serial link ports, grouped in pairs. While reset is held, every port loads one shared 2-bit rate strap and its own power-down strap. After reset, a host or a boot loader changes a port through a single-cycle write strobe. The block only lets a port's rate change while that port is powered down, so the legal sequence is: power the port down, write the new code, then power it up.

The block also forces both ports of a pair onto one rate when the pair runs in 1x mode. It keeps ports out of link initialization while a boot-time configuration load is running. When a port comes back up, it issues a one-cycle restart request. The serializer, the clock synthesizer and link training sit outside the block and consume its outputs.

Top module: `prc_rate_ctrl`

## Requirements
- R1: While `rst_n` is low, every port's configured rate loads from `strap_rate`. The first cycle after release therefore shows the same code on every port of `eff_rate`. Port p uses bits [2p+1:2p].
- R2: A write (`wr_en`=1, `wr_rate_en`=1) to a port whose `pwrdn` bit is 1, carrying a legal code, replaces that port's rate from the next cycle on.
- R3: A rate write is judged against the power-down state before that same write. If the port's `pwrdn` is 0, the rate is left unchanged, even when the same write also sets the power-down bit.
- R4: While reset is held, `pwrdn` loads `strap_pwrdn`. A port stays powered down until a write with `wr_pd_en`=1 and `wr_pd`=0 clears it. Such a write takes effect on the next cycle.
- R5: A rejected rate write sets the sticky `rate_err` bit of that port on the next cycle. A 1 on `err_clr[p]` clears it on the next cycle. A simultaneous set wins over a clear.
- R6: Pair k is ports 2k (lower) and 2k+1. While `pair_1x[k]`=1, both ports show the lower port's configured rate on `eff_rate`. While it is 0, each port shows its own rate.
- R7: When a port's `pwrdn` goes from 1 to 0, `restart[p]` is high for exactly one cycle. That cycle is the first cycle at or after the change in which `boot_busy` is 0. Powering down again before that cycle cancels the request.
- R8: `init_en[p]` is 1 exactly when the port's `pwrdn` is 0 and `boot_busy` is 0.
- R9: Rate code 2'b11 is illegal. A write carrying it is rejected like R3 and sets `rate_err`. A strap of 2'b11 loads code 2'b00 into every port and sets `strap_bad` until the next reset with a legal strap.
- R10: For the port selected by `rd_port`, `rd_pwrdn`, `rd_rate` and `rd_err` show that port's `pwrdn`, `eff_rate` field and `rate_err` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; straps are sampled while it is low |
| strap_rate | input | 2 | Shared power-up rate strap |
| strap_pwrdn | input | NUM_PORTS | Per-port power-down strap |
| boot_busy | input | 1 | Boot-time configuration load in progress |
| pair_1x | input | NUM_PORTS/2 | Pair k runs both ports in 1x mode |
| wr_en | input | 1 | Single-cycle write strobe |
| wr_port | input | IDX_W | Target port of the write |
| wr_pd_en | input | 1 | Write enable for the power-down bit |
| wr_pd | input | 1 | New power-down bit |
| wr_rate_en | input | 1 | Write enable for the rate field |
| wr_rate | input | 2 | New rate code |
| err_clr | input | NUM_PORTS | Per-port clear of the sticky error flag |
| rd_port | input | IDX_W | Read-back port select |
| eff_rate | output | 2*NUM_PORTS | Effective rate code per port |
| pwrdn | output | NUM_PORTS | Power-down state per port |
| init_en | output | NUM_PORTS | Link initialization allowed |
| restart | output | NUM_PORTS | One-cycle restart request after power-up |
| rate_err | output | NUM_PORTS | Sticky rejected-write flag |
| strap_bad | output | 1 | Illegal rate strap seen at the last reset |
| rd_pwrdn | output | 1 | Read-back power-down bit |
| rd_rate | output | 2 | Read-back effective rate |
| rd_err | output | 1 | Read-back error flag |

## Verification
The assertions assume that the straps are held steady for at least two clock edges while reset is low. That assumption lets a change of the lower port's rate after release be traced to a powered-down cycle. They also assume that `wr_en` is low during reset. The stimulus holds reset for three cycles and keeps every strobe idle meanwhile. It applies each input change once per cycle, on the falling clock edge. It re-enters reset only with the write interface quiet, so every rate change the checker sees comes from a write issued while the port was down.

// File: rtl/prc_pkg.sv
package prc_pkg;

    localparam int RATE_W = 2;

    typedef logic [RATE_W-1:0] rate_t;

    localparam rate_t RATE_BAD  = 2'b11;
    localparam rate_t RATE_SAFE = 2'b00;

    typedef struct packed {
        logic  pd;
        rate_t rate;
        logic  err;
        logic  pend;
    } slot_t;

    function automatic logic rate_ok(input rate_t r);
        return r != RATE_BAD;
    endfunction

endpackage

// File: rtl/prc_port_slot.sv
module prc_port_slot
    import prc_pkg::*;
#(
    parameter int PORT_IDX = 0,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  rate_t            boot_rate,
    input  logic             boot_pd,
    input  logic             boot_busy,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_port,
    input  logic             wr_pd_en,
    input  logic             wr_pd,
    input  logic             wr_rate_en,
    input  rate_t            wr_rate,
    input  logic             err_clr,
    output logic             pd_o,
    output rate_t            rate_o,
    output logic             err_o,
    output logic             restart_o
);

    localparam logic [IDX_W-1:0] MY_IDX = IDX_W'(PORT_IDX);

    slot_t slot_d, slot_q;
    logic  hit, reject, issue;

    always_comb begin
        slot_d = slot_q;
        hit    = wr_en && (wr_port == MY_IDX);
        issue  = slot_q.pend && !boot_busy && !slot_q.pd;
        reject = 1'b0;

        // rate field is judged against the power state before this write
        if (hit && wr_rate_en) begin
            if (slot_q.pd && rate_ok(wr_rate)) begin
                slot_d.rate = wr_rate;
            end else begin
                reject = 1'b1;
            end
        end

        if (err_clr) begin
            slot_d.err = 1'b0;
        end
        if (reject) begin
            slot_d.err = 1'b1;
        end

        if (hit && wr_pd_en) begin
            slot_d.pd = wr_pd;
        end

        if (issue) begin
            slot_d.pend = 1'b0;
        end
        if (slot_q.pd && !slot_d.pd) begin
            slot_d.pend = 1'b1;
        end
        if (slot_d.pd) begin
            slot_d.pend = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_q <= '{pd: boot_pd, rate: boot_rate, err: 1'b0, pend: 1'b0};
        end else begin
            slot_q <= slot_d;
        end
    end

    assign pd_o      = slot_q.pd;
    assign rate_o    = slot_q.rate;
    assign err_o     = slot_q.err;
    assign restart_o = issue;

endmodule

// File: rtl/prc_pair_merge.sv
module prc_pair_merge
    import prc_pkg::*;
#(
    parameter int NUM_PAIRS = 2
) (
    input  rate_t [2*NUM_PAIRS-1:0] cfg_rate,
    input  logic  [NUM_PAIRS-1:0]   pair_1x,
    output rate_t [2*NUM_PAIRS-1:0] out_rate
);

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair
        assign out_rate[2*k]   = cfg_rate[2*k];
        assign out_rate[2*k+1] = pair_1x[k] ? cfg_rate[2*k] : cfg_rate[2*k+1];
    end

endmodule

// File: rtl/prc_rate_ctrl.sv
module prc_rate_ctrl
    import prc_pkg::*;
#(
    parameter  int NUM_PORTS = 4,
    localparam int NUM_PAIRS = NUM_PORTS / 2,
    localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic [1:0]             strap_rate,
    input  logic [NUM_PORTS-1:0]   strap_pwrdn,
    input  logic                   boot_busy,
    input  logic [NUM_PAIRS-1:0]   pair_1x,
    input  logic                   wr_en,
    input  logic [IDX_W-1:0]       wr_port,
    input  logic                   wr_pd_en,
    input  logic                   wr_pd,
    input  logic                   wr_rate_en,
    input  logic [1:0]             wr_rate,
    input  logic [NUM_PORTS-1:0]   err_clr,
    input  logic [IDX_W-1:0]       rd_port,
    output logic [2*NUM_PORTS-1:0] eff_rate,
    output logic [NUM_PORTS-1:0]   pwrdn,
    output logic [NUM_PORTS-1:0]   init_en,
    output logic [NUM_PORTS-1:0]   restart,
    output logic [NUM_PORTS-1:0]   rate_err,
    output logic                   strap_bad,
    output logic                   rd_pwrdn,
    output logic [1:0]             rd_rate,
    output logic                   rd_err
);

    typedef struct packed {
        logic strap_bad;
    } top_t;

    top_t  top_d, top_q;
    rate_t boot_rate;
    rate_t [NUM_PORTS-1:0] cfg_rate;
    rate_t [NUM_PORTS-1:0] out_rate;

    assign boot_rate = rate_ok(strap_rate) ? strap_rate : RATE_SAFE;

    always_comb begin
        top_d = top_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            top_q.strap_bad <= !rate_ok(strap_rate);
        end else begin
            top_q <= top_d;
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        prc_port_slot #(
            .PORT_IDX (p),
            .IDX_W    (IDX_W)
        ) slot_i (
            .clk        (clk),
            .rst_n      (rst_n),
            .boot_rate  (boot_rate),
            .boot_pd    (strap_pwrdn[p]),
            .boot_busy  (boot_busy),
            .wr_en      (wr_en),
            .wr_port    (wr_port),
            .wr_pd_en   (wr_pd_en),
            .wr_pd      (wr_pd),
            .wr_rate_en (wr_rate_en),
            .wr_rate    (wr_rate),
            .err_clr    (err_clr[p]),
            .pd_o       (pwrdn[p]),
            .rate_o     (cfg_rate[p]),
            .err_o      (rate_err[p]),
            .restart_o  (restart[p])
        );

        assign init_en[p]          = !pwrdn[p] && !boot_busy;
        assign eff_rate[2*p +: 2]  = out_rate[p];
    end

    prc_pair_merge #(
        .NUM_PAIRS (NUM_PAIRS)
    ) merge_i (
        .cfg_rate (cfg_rate),
        .pair_1x  (pair_1x),
        .out_rate (out_rate)
    );

    assign strap_bad = top_q.strap_bad;
    assign rd_pwrdn  = pwrdn[rd_port];
    assign rd_rate   = out_rate[rd_port];
    assign rd_err    = rate_err[rd_port];

endmodule

// File: rtl/prc_rate_ctrl_chk.sv
module prc_rate_ctrl_chk #(
    parameter  int NUM_PORTS = 4,
    localparam int NUM_PAIRS = NUM_PORTS / 2,
    localparam int IDX_W     = (NUM_PORTS > 1) ? $clog2(NUM_PORTS) : 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   boot_busy,
    input logic [NUM_PAIRS-1:0]   pair_1x,
    input logic                   wr_en,
    input logic [IDX_W-1:0]       wr_port,
    input logic                   wr_pd_en,
    input logic                   wr_pd,
    input logic                   wr_rate_en,
    input logic [2*NUM_PORTS-1:0] eff_rate,
    input logic [NUM_PORTS-1:0]   pwrdn,
    input logic [NUM_PORTS-1:0]   init_en,
    input logic [NUM_PORTS-1:0]   restart,
    input logic [NUM_PORTS-1:0]   rate_err
);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        localparam logic [IDX_W-1:0] PIDX = IDX_W'(p);

        // R4
        wake_by_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(pwrdn[p]) |-> $past(wr_en && wr_port == PIDX && wr_pd_en && !wr_pd));

        // R5
        reject_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (wr_en && wr_rate_en && wr_port == PIDX && !pwrdn[p]) |=> rate_err[p]);

        // R7
        restart_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
            restart[p] |=> !restart[p]);

        // R8
        restart_vs_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
            restart[p] |-> init_en[p]);

        // R9
        no_bad_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
            eff_rate[2*p +: 2] != 2'b11);
    end

    for (genvar k = 0; k < NUM_PAIRS; k++) begin : g_pair_chk
        // R3
        change_while_down_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !$stable(eff_rate[4*k +: 2]) |-> $past(pwrdn[2*k]));

        // R6
        pair_locked_chk: assert property (@(posedge clk) disable iff (!rst_n)
            pair_1x[k] |-> eff_rate[4*k +: 2] == eff_rate[4*k+2 +: 2]);
    end

endmodule

bind prc_rate_ctrl prc_rate_ctrl_chk #(
    .NUM_PORTS (NUM_PORTS)
) chk_i (
    .clk        (clk),
    .rst_n      (rst_n),
    .boot_busy  (boot_busy),
    .pair_1x    (pair_1x),
    .wr_en      (wr_en),
    .wr_port    (wr_port),
    .wr_pd_en   (wr_pd_en),
    .wr_pd      (wr_pd),
    .wr_rate_en (wr_rate_en),
    .eff_rate   (eff_rate),
    .pwrdn      (pwrdn),
    .init_en    (init_en),
    .restart    (restart),
    .rate_err   (rate_err)
);

// File: tb/prc_rate_ctrl_tb_top.sv
module prc_rate_ctrl_tb_top;

    localparam int NP = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [1:0]    strap_rate = 2'b00;
    logic [NP-1:0] strap_pwrdn = '0;
    logic          boot_busy = 1'b0;
    logic [1:0]    pair_1x = '0;
    logic          wr_en = 1'b0;
    logic [1:0]    wr_port = '0;
    logic          wr_pd_en = 1'b0;
    logic          wr_pd = 1'b0;
    logic          wr_rate_en = 1'b0;
    logic [1:0]    wr_rate = '0;
    logic [NP-1:0] err_clr = '0;
    logic [1:0]    rd_port = '0;
    logic [2*NP-1:0] eff_rate;
    logic [NP-1:0] pwrdn, init_en, restart, rate_err;
    logic          strap_bad, rd_pwrdn, rd_err;
    logic [1:0]    rd_rate;

    always #2.5 clk = ~clk;

    prc_rate_ctrl #(.NUM_PORTS(NP)) dut_i (
        .clk(clk), .rst_n(rst_n), .strap_rate(strap_rate), .strap_pwrdn(strap_pwrdn),
        .boot_busy(boot_busy), .pair_1x(pair_1x), .wr_en(wr_en), .wr_port(wr_port),
        .wr_pd_en(wr_pd_en), .wr_pd(wr_pd), .wr_rate_en(wr_rate_en), .wr_rate(wr_rate),
        .err_clr(err_clr), .rd_port(rd_port), .eff_rate(eff_rate), .pwrdn(pwrdn),
        .init_en(init_en), .restart(restart), .rate_err(rate_err), .strap_bad(strap_bad),
        .rd_pwrdn(rd_pwrdn), .rd_rate(rd_rate), .rd_err(rd_err)
    );

    typedef struct {
        string     tag;
        logic [7:0] eff;
        logic [3:0] pd;
        logic [3:0] err;
        logic [3:0] init;
        logic [3:0] rst;
        logic       bad;
        logic [3:0] rd;
    } exp_t;

    exp_t sb_q[$];
    int   n_chk = 0;
    int   n_bad = 0;
    bit   done = 1'b0;

    // reference model state
    logic [1:0] m_rate [NP];
    logic [3:0] m_pd, m_err, m_pend;
    logic       m_bad;

    task automatic model_reset(input logic [1:0] s, input logic [3:0] spd);
        for (int p = 0; p < NP; p++) m_rate[p] = (s == 2'b11) ? 2'b00 : s;
        m_pd   = spd;
        m_err  = '0;
        m_pend = '0;
        m_bad  = (s == 2'b11);
    endtask

    task automatic do_reset(input logic [1:0] s, input logic [3:0] spd);
        @(negedge clk);
        rst_n = 1'b0; strap_rate = s; strap_pwrdn = spd;
        wr_en = 1'b0; err_clr = '0; boot_busy = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        model_reset(s, spd);
    endtask

    // one cycle: apply inputs at the falling edge, predict this cycle, advance the model
    task automatic cyc(input string tag, input bit we, input int port,
                       input bit pde, input bit pdv, input bit re, input logic [1:0] rv,
                       input logic [3:0] clr, input bit busy, input logic [1:0] pr);
        exp_t e;
        logic [3:0] nxt_pd;
        @(negedge clk);
        if (sb_q.size() == 0 && n_chk == 0) begin end
        wr_en = we; wr_port = 2'(port); wr_pd_en = pde; wr_pd = pdv;
        wr_rate_en = re; wr_rate = rv; err_clr = clr; boot_busy = busy; pair_1x = pr;
        rd_port = 2'(n_chk % NP);
        e.tag = tag;
        for (int p = 0; p < NP; p++) begin
            e.eff[2*p +: 2] = (p % 2 == 1 && pr[p/2]) ? m_rate[p-1] : m_rate[p];
        end
        e.pd   = m_pd;
        e.err  = m_err;
        e.init = ~m_pd & {4{~busy}};
        e.rst  = m_pend & ~m_pd & {4{~busy}};
        e.bad  = m_bad;
        e.rd   = {m_pd[n_chk % NP], e.eff[2*(n_chk % NP) +: 2], m_err[n_chk % NP]};
        sb_q.push_back(e);
        for (int p = 0; p < NP; p++) begin
            bit hit = we && (port == p);
            bit rej = 1'b0;
            if (hit && re) begin
                if (m_pd[p] && rv != 2'b11) m_rate[p] = rv;
                else rej = 1'b1;
            end
            if (clr[p]) m_err[p] = 1'b0;
            if (rej) m_err[p] = 1'b1;
            nxt_pd[p] = (hit && pde) ? pdv : m_pd[p];
            if (e.rst[p]) m_pend[p] = 1'b0;
            if (m_pd[p] && !nxt_pd[p]) m_pend[p] = 1'b1;
            if (nxt_pd[p]) m_pend[p] = 1'b0;
        end
        m_pd = nxt_pd;
    endtask

    task automatic idle(input string tag, input bit busy, input logic [1:0] pr);
        cyc(tag, 1'b0, 0, 1'b0, 1'b0, 1'b0, 2'b00, 4'b0000, busy, pr);
    endtask

    // monitor: pops one expectation per cycle, shortly after the falling edge
    initial begin
        forever begin
            @(negedge clk);
            #1;
            if (sb_q.size() > 0) begin
                exp_t e;
                logic [3:0] rd_act;
                e = sb_q.pop_front();
                rd_act = {rd_pwrdn, rd_rate, rd_err};
                n_chk++;
                if (eff_rate !== e.eff || pwrdn !== e.pd || rate_err !== e.err ||
                    init_en !== e.init || restart !== e.rst || strap_bad !== e.bad ||
                    rd_act !== e.rd) begin
                    n_bad++;
                    $display("FAIL %s: act eff=%b pd=%b err=%b init=%b rst=%b bad=%b rd=%b exp eff=%b pd=%b err=%b init=%b rst=%b bad=%b rd=%b",
                             e.tag, eff_rate, pwrdn, rate_err, init_en, restart, strap_bad, rd_act,
                             e.eff, e.pd, e.err, e.init, e.rst, e.bad, e.rd);
                end
            end
        end
    end

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog: act running exp finished");
            $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        // R1 R4: shared strap rate 2'b10, ports 0 and 1 strapped down
        do_reset(2'b10, 4'b0011);
        idle("R1 R4 R8 reset state", 1'b0, 2'b00);
        // R3 R5: rate write to a powered-up port is ignored and flagged
        cyc("R3 write to live port", 1'b1, 2, 1'b0, 1'b0, 1'b1, 2'b01, 4'b0000, 1'b0, 2'b00);
        idle("R5 error set, rate kept", 1'b0, 2'b00);
        cyc("R5 clear error", 1'b0, 0, 1'b0, 1'b0, 1'b0, 2'b00, 4'b0100, 1'b0, 2'b00);
        idle("R5 error cleared R10", 1'b0, 2'b00);
        // R2: legal sequence on port 2
        cyc("R2 power down", 1'b1, 2, 1'b1, 1'b1, 1'b0, 2'b00, 4'b0000, 1'b0, 2'b00);
        cyc("R2 write rate", 1'b1, 2, 1'b0, 1'b0, 1'b1, 2'b01, 4'b0000, 1'b0, 2'b00);
        cyc("R2 power up", 1'b1, 2, 1'b1, 1'b0, 1'b0, 2'b00, 4'b0000, 1'b0, 2'b00);
        idle("R7 restart pulse", 1'b0, 2'b00);
        idle("R7 pulse ends", 1'b0, 2'b00);
        // R6: pair 0 in 1x follows port 0
        cyc("R6 lower port rate", 1'b1, 0, 1'b0, 1'b0, 1'b1, 2'b01, 4'b0000, 1'b0, 2'b01);
        idle("R6 pair forced", 1'b0, 2'b01);
        idle("R6 pair released", 1'b0, 2'b00);
        // R9: illegal code on a powered-down port
        cyc("R9 illegal write", 1'b1, 1, 1'b0, 1'b0, 1'b1, 2'b11, 4'b0000, 1'b0, 2'b00);
        idle("R9 rejected", 1'b0, 2'b00);
        // R3: combined down+rate on a live port judged on old state
        cyc("R3 combined write", 1'b1, 3, 1'b1, 1'b1, 1'b1, 2'b00, 4'b0000, 1'b0, 2'b00);
        idle("R3 rate kept, port down", 1'b0, 2'b00);
        // R7 R8: boot load busy holds back init and restart
        cyc("R8 wake under busy", 1'b1, 0, 1'b1, 1'b0, 1'b0, 2'b00, 4'b0000, 1'b1, 2'b00);
        idle("R7 suppressed", 1'b1, 2'b00);
        idle("R7 R8 still busy", 1'b1, 2'b00);
        idle("R7 issued after busy", 1'b0, 2'b00);
        idle("R7 single pulse", 1'b0, 2'b00);
        // R7: power down again before the pulse cancels it
        cyc("R7 wake port 3 busy", 1'b1, 3, 1'b1, 1'b0, 1'b0, 2'b00, 4'b0000, 1'b1, 2'b00);
        cyc("R7 re-down", 1'b1, 3, 1'b1, 1'b1, 1'b0, 2'b00, 4'b0000, 1'b1, 2'b00);
        idle("R7 cancelled", 1'b0, 2'b00);
        idle("R7 cancelled hold", 1'b0, 2'b00);
        // R9: illegal strap
        do_reset(2'b11, 4'b0000);
        idle("R9 strap illegal", 1'b0, 2'b00);
        idle("R9 strap flag hold", 1'b0, 2'b11);
        do_reset(2'b01, 4'b1111);
        idle("R1 R9 legal strap", 1'b0, 2'b00);
        idle("R10 readback", 1'b0, 2'b00);
        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            n_bad++;
            $display("FAIL scoreboard: act %0d left exp 0", sb_q.size());
        end
        done = 1'b1;
        $display("[TB] %0d tests run, %0d failed", n_chk, n_bad);
        $finish;
    end

endmodule